// File: doc/BRIEF.md
# Glitch-Free System Clock Source Selector

This block chooses which of two free-running clocks drives the system clock: an internal RC oscillator or an external crystal. A single request input asks for the crystal when high and for the RC oscillator when low. When the RC path is wanted, the block drives the RC oscillator enable. If the oscillator is already reported as running, the block starts the handover at once. If it is not running, the block first waits four RC clock periods for start-up. A status output reports which source is really gating the system clock at that moment, which is not always the source being asked for.

The handover is break-before-make. Each clock branch has its own gate flop, updated on that clock's falling edge. A branch opens only after it has seen, through a two-stage synchroniser in its own domain, that the other branch's gate is closed. Oscillator behaviour is modelled as two ideal clock inputs. Crystal warm-up is not counted.

The controller is a state machine clocked by the RC clock:
- ST_IDLE is the state after reset, with no source gated. It moves to ST_BOOT_WARM when RC is wanted and the oscillator is cold. It moves to ST_HANDOVER when RC is wanted and the oscillator is running. It moves to ST_TO_XTAL when the crystal is wanted.
- ST_BOOT_WARM and ST_WARM each count four RC cycles and then move to ST_HANDOVER. ST_WARM keeps the crystal gated while it waits.
- ST_HANDOVER moves to ST_RC once the RC gate is open.
- ST_RC moves to ST_TO_XTAL when the crystal is requested.
- ST_TO_XTAL moves to ST_XTAL once the RC gate is shut and the crystal gate is seen open.
- ST_XTAL moves to ST_HANDOVER (RC running) or to ST_WARM (RC cold) when RC is requested.

Top module: `clk_source_sel`

## Requirements
- R1: While reset is held and right after it, `rc_active` is 0 and `rc_en` is 0.
- R2: With `sel_xtal` low (the RC oscillator is the default source), `rc_active` rises to 1 within 60 RC cycles of reset release, and `sys_clk` then runs at the RC clock period.
- R3: When RC is requested while `rc_running` is 0, `rc_en` rises first and `rc_active` stays 0 for at least four RC cycles after that rise.
- R4: When RC is requested while `rc_running` is 1, there is no start-up wait. The latency from request to `rc_active`=1 is 3 to 5 RC cycles shorter than for the same request with `rc_running`=0.
- R5: With `sel_xtal` high, the crystal ends up driving `sys_clk` (at the crystal period), with `rc_active`=0 and `rc_en`=0.
- R6: `rc_active` is 1 only while `rc_en` is 1.
- R7: The handover is glitch-free. The two branch gates are never open together, and no high or low phase of `sys_clk` is shorter than the shorter half period of the two sources.
- R8: `rc_active` rises only after `rc_en` was already 1 in the previous RC cycle, that is, after the new source's enable has been synchronised and its gate opened.
- R9: `rsvd_zero`, the unused status bit beside `rc_active`, always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rc_clk | input | 1 | Internal RC oscillator clock; also clocks the controller |
| xtal_clk | input | 1 | External crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset, covering every form of reset |
| sel_xtal | input | 1 | Source request: 1 = crystal, 0 = RC oscillator |
| rc_running | input | 1 | Indication that the RC oscillator is already running |
| sys_clk | output | 1 | Gated system clock |
| rc_en | output | 1 | RC oscillator enable |
| rc_active | output | 1 | Status: 1 = RC drives sys_clk, 0 = crystal or none |
| rsvd_zero | output | 1 | Unused status bit, constant 0 |

## Verification
Four properties are checked on every RC cycle:
- the two branch gates are never open at once;
- the status is never high without the RC enable;
- the status rises only after the enable was already high;
- a cold start never reports RC in the cycle after the enable rises.

Some behaviour can only be shown by the directed scenarios, because it depends on timing across both clock domains or on measured pulse widths:
- the four-cycle start-up gap;
- the latency difference between a cold and a warm switch;
- the measured output period after each switch;
- the minimum `sys_clk` phase width across every handover.

// File: rtl/ccs_pkg.sv
`timescale 1ns/1ps
package ccs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BOOT_WARM,
        ST_WARM,
        ST_HANDOVER,
        ST_RC,
        ST_TO_XTAL,
        ST_XTAL
    } ccs_state_e;
endpackage

// File: rtl/ccs_sync.sv
`timescale 1ns/1ps
module ccs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ccs_branch.sv
`timescale 1ns/1ps
module ccs_branch #(
    parameter int SYNC_STAGES = 2,
    parameter bit SYNC_WANT   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic other_gate,
    output logic other_seen,
    output logic gate,
    output logic clk_out
);
    logic want_s;
    logic gate_q;

    generate
        if (SYNC_WANT) begin : g_want_sync
            ccs_sync #(.STAGES(SYNC_STAGES)) u_want_sync (
                .clk(clk), .rst_n(rst_n), .d(want), .q(want_s)
            );
        end else begin : g_want_direct
            assign want_s = want;
        end
    endgenerate

    ccs_sync #(.STAGES(SYNC_STAGES)) u_other_sync (
        .clk(clk), .rst_n(rst_n), .d(other_gate), .q(other_seen)
    );

    // gate moves only while clk is low, so the AND below never chops a phase
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= want_s & ~other_seen;
    end

    assign gate    = gate_q;
    assign clk_out = clk & gate_q;
endmodule

// File: rtl/ccs_fsm.sv
`timescale 1ns/1ps
module ccs_fsm
    import ccs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WARM_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_xtal,
    input  logic rc_running,
    input  logic rc_gate,
    input  logic xt_seen,
    output logic rc_en,
    output logic want_rc,
    output logic want_xt,
    output logic rc_active
);
    localparam int CW = $clog2(WARM_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WARM_CYCLES - 1);

    ccs_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic sel_s, run_s, warm_done;

    ccs_sync #(.STAGES(SYNC_STAGES)) u_sel_sync (
        .clk(clk), .rst_n(rst_n), .d(sel_xtal), .q(sel_s)
    );
    ccs_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
        .clk(clk), .rst_n(rst_n), .d(rc_running), .q(run_s)
    );

    assign warm_done = (cnt_q == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      state_d = sel_s ? ST_TO_XTAL
                                          : (run_s ? ST_HANDOVER : ST_BOOT_WARM);
            ST_BOOT_WARM: if (warm_done) state_d = ST_HANDOVER;
            ST_WARM:      if (warm_done) state_d = ST_HANDOVER;
            ST_HANDOVER:  if (rc_gate) state_d = ST_RC;
            ST_RC:        if (sel_s) state_d = ST_TO_XTAL;
            ST_TO_XTAL:   if (xt_seen && !rc_gate) state_d = ST_XTAL;
            ST_XTAL:      if (!sel_s) state_d = run_s ? ST_HANDOVER : ST_WARM;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_BOOT_WARM || state_d == ST_WARM) begin
                if (state_q == state_d) cnt_q <= cnt_q + 1'b1;
                else                    cnt_q <= '0;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rc_en     <= 1'b0;
            want_rc   <= 1'b0;
            want_xt   <= 1'b0;
            rc_active <= 1'b0;
        end else begin
            rc_en     <= (state_d inside {ST_BOOT_WARM, ST_WARM, ST_HANDOVER,
                                          ST_RC, ST_TO_XTAL});
            want_rc   <= (state_d inside {ST_HANDOVER, ST_RC});
            want_xt   <= (state_d inside {ST_WARM, ST_TO_XTAL, ST_XTAL});
            rc_active <= rc_gate;
        end
    end
endmodule

// File: rtl/clk_source_sel.sv
`timescale 1ns/1ps
module clk_source_sel #(
    parameter int SYNC_STAGES = 2,
    parameter int WARM_CYCLES = 4
) (
    input  logic rc_clk,
    input  logic xtal_clk,
    input  logic rst_n,
    input  logic sel_xtal,
    input  logic rc_running,
    output logic sys_clk,
    output logic rc_en,
    output logic rc_active,
    output logic rsvd_zero
);
    logic want_rc, want_xt;
    logic rc_gate_w, xt_gate_w;
    logic xt_seen_rc, rc_seen_xt;
    logic rc_clk_g, xt_clk_g;

    ccs_fsm #(.SYNC_STAGES(SYNC_STAGES), .WARM_CYCLES(WARM_CYCLES)) u_fsm (
        .clk(rc_clk), .rst_n(rst_n), .sel_xtal(sel_xtal),
        .rc_running(rc_running), .rc_gate(rc_gate_w), .xt_seen(xt_seen_rc),
        .rc_en(rc_en), .want_rc(want_rc), .want_xt(want_xt),
        .rc_active(rc_active)
    );

    ccs_branch #(.SYNC_STAGES(SYNC_STAGES), .SYNC_WANT(1'b0)) u_rc_branch (
        .clk(rc_clk), .rst_n(rst_n), .want(want_rc), .other_gate(xt_gate_w),
        .other_seen(xt_seen_rc), .gate(rc_gate_w), .clk_out(rc_clk_g)
    );

    ccs_branch #(.SYNC_STAGES(SYNC_STAGES), .SYNC_WANT(1'b1)) u_xt_branch (
        .clk(xtal_clk), .rst_n(rst_n), .want(want_xt), .other_gate(rc_gate_w),
        .other_seen(rc_seen_xt), .gate(xt_gate_w), .clk_out(xt_clk_g)
    );

    assign sys_clk   = rc_clk_g | xt_clk_g;
    assign rsvd_zero = 1'b0;

    logic unused_w;
    assign unused_w = rc_seen_xt;
endmodule

// File: rtl/ccs_checker.sv
`timescale 1ns/1ps
module ccs_checker (
    input logic rc_clk,
    input logic rst_n,
    input logic rc_en,
    input logic rc_active,
    input logic rc_running,
    input logic rc_gate,
    input logic xt_gate
);
    // R7
    gates_exclusive_chk: assert property (@(posedge rc_clk) disable iff (!rst_n)
        !(rc_gate && xt_gate));

    // R6
    status_needs_en_chk: assert property (@(posedge rc_clk) disable iff (!rst_n)
        rc_active |-> rc_en);

    // R8
    en_before_status_chk: assert property (@(posedge rc_clk) disable iff (!rst_n)
        $rose(rc_active) |-> $past(rc_en));

    // R3
    cold_no_jump_chk: assert property (@(posedge rc_clk) disable iff (!rst_n)
        ($rose(rc_en) && !rc_running) |=> !rc_active);
endmodule

bind clk_source_sel ccs_checker u_ccs_checker (
    .rc_clk(rc_clk), .rst_n(rst_n), .rc_en(rc_en), .rc_active(rc_active),
    .rc_running(rc_running), .rc_gate(rc_gate_w), .xt_gate(xt_gate_w)
);

// File: tb/clk_source_sel_test.sv
`timescale 1ns/1ps
module clk_source_sel_test;
    logic rc_clk = 1'b0, xtal_clk = 1'b0, rst_n = 1'b0;
    logic sel_xtal = 1'b0, rc_running = 1'b0;
    logic sys_clk, rc_en, rc_active, rsvd_zero;

    int checks = 0, errors = 0;
    int glitches = 0;
    bit mon_on = 1'b0, done = 1'b0;
    realtime last_edge = 0.0;
    int lat_cold = 0, lat_warm = 0;

    always #4 rc_clk = ~rc_clk;     // 125 MHz
    always #5 xtal_clk = ~xtal_clk; // crystal, 100 MHz

    clk_source_sel uut (
        .rc_clk(rc_clk), .xtal_clk(xtal_clk), .rst_n(rst_n),
        .sel_xtal(sel_xtal), .rc_running(rc_running), .sys_clk(sys_clk),
        .rc_en(rc_en), .rc_active(rc_active), .rsvd_zero(rsvd_zero)
    );

    // phase-width monitor for R7
    always @(sys_clk) begin
        if (mon_on && ($realtime - last_edge) < 3.9) glitches++;
        last_edge = $realtime;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic measure_period(output int ps);
        realtime t0;
        @(posedge sys_clk); t0 = $realtime;
        @(posedge sys_clk); ps = int'(($realtime - t0) * 1000.0);
    endtask

    // counts RC cycles from now until rc_active==want; also when rc_en first high
    task automatic wait_status(input logic want, output int n, output int en_at);
        n = 0; en_at = -1;
        while (rc_active !== want && n < 200) begin
            @(negedge rc_clk); n++;
            if (en_at < 0 && rc_en === 1'b1) en_at = n;
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge rc_clk);
        chk(rc_active === 1'b0, "R1", "status in reset", int'(rc_active), 0);
        chk(rc_en === 1'b0, "R1", "rc_en in reset", int'(rc_en), 0);
        chk(rsvd_zero === 1'b0, "R9", "spare bit in reset", int'(rsvd_zero), 0);
        rst_n = 1'b1;
        @(negedge rc_clk);
        chk(rc_active === 1'b0, "R1", "status just after reset", int'(rc_active), 0);
        mon_on = 1'b1;
    endtask

    task automatic t_boot;
        int n, en_at, p;
        wait_status(1'b1, n, en_at);
        chk(n < 60, "R2", "boot cycles to RC", n, 59);
        chk(en_at >= 0 && (n - en_at) >= 4, "R3", "boot gap after rc_en", n - en_at, 4);
        measure_period(p);
        chk(p > 7900 && p < 8100, "R2", "sys_clk period ps on RC", p, 8000);
        chk(rsvd_zero === 1'b0, "R9", "spare bit on RC", int'(rsvd_zero), 0);
    endtask

    task automatic t_to_xtal;
        int n, en_at, p;
        @(negedge rc_clk); sel_xtal = 1'b1;
        wait_status(1'b0, n, en_at);
        repeat (20) @(negedge rc_clk);
        chk(rc_active === 1'b0, "R5", "status on crystal", int'(rc_active), 0);
        chk(rc_en === 1'b0, "R5", "rc_en on crystal", int'(rc_en), 0);
        measure_period(p);
        chk(p > 9900 && p < 10100, "R5", "sys_clk period ps on crystal", p, 10000);
        chk(rsvd_zero === 1'b0, "R9", "spare bit on crystal", int'(rsvd_zero), 0);
    endtask

    task automatic t_cold;
        int n, en_at;
        rc_running = 1'b0;
        repeat (5) @(negedge rc_clk);
        sel_xtal = 1'b0;
        wait_status(1'b1, n, en_at);
        lat_cold = n;
        chk(en_at >= 0 && (n - en_at) >= 4, "R3", "cold gap after rc_en", n - en_at, 4);
        chk(rc_en === 1'b1, "R6", "rc_en while status high", int'(rc_en), 1);
    endtask

    task automatic t_warm;
        int n, en_at, d;
        rc_running = 1'b1;
        repeat (5) @(negedge rc_clk);
        sel_xtal = 1'b0;
        wait_status(1'b1, n, en_at);
        lat_warm = n;
        d = lat_cold - lat_warm;
        chk(d >= 3 && d <= 5, "R4", "cold minus warm latency", d, 4);
        chk(rc_active === 1'b1, "R4", "warm switch reached RC", int'(rc_active), 1);
    endtask

    initial begin
        t_reset();
        t_boot();
        t_to_xtal();
        t_cold();
        t_to_xtal();
        t_warm();
        t_to_xtal();
        chk(glitches == 0, "R7", "short sys_clk phases", glitches, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule